// File: doc/BRIEF.md
# Mappable Interrupt Router with Level and Pulse Outputs

This block collects single-bit event conditions from the rest of a device and turns them into host interrupts. It drives three active-low general-purpose interrupt pins and one active-low error pin. Each condition has a two-bit routing field that sends it to one of the three pins. A field value of 0 routes it nowhere, so the condition is disabled. Each pin has its own mode: it either holds low until the host services it, or it drops for a fixed number of clock cycles and then returns high.

The host reaches the block through a simple register port. It has a write strobe, a read strobe, a 3-bit address, write data, and read data that is valid in the same cycle as the read strobe.

Reading a status register clears it. The clear takes effect at the clock edge that ends the read.

Masking acts on the pins only. Events that arrive while a pin is masked still latch into status. If the pin is in hold mode, it asserts as soon as the mask is lifted.

Each general-purpose pin is driven by its own small state machine with three states:
- `OUT_IDLE`: the pin is high.
- `OUT_LEVEL`: the pin is held low.
- `OUT_PULSE`: the pin is low for a counted window.

The state machine takes these transitions:
- **arm-level** (`OUT_IDLE` → `OUT_LEVEL`): unmasked, hold mode, and status is pending.
- **fire-pulse** (`OUT_IDLE` → `OUT_PULSE`): unmasked, pulse mode, and a new event has latched.
- **release** (`OUT_LEVEL` → `OUT_IDLE`): status is cleared, or the mask is set, or pulse mode is selected.
- **expire** (`OUT_PULSE` → `OUT_IDLE`): the pulse counter reaches zero.

In every other case the state machine stays where it is.

Top module: `irq_router`

## Requirements
- R1: After reset:
  - all four pins are high;
  - every status register reads 0;
  - the routing register (address 2) reads 0;
  - the mask register (address 0) reads 7, meaning all pins are masked;
  - the mode register (address 1) reads 0, meaning hold mode.
- R2: A rising edge on condition c latches bit c of the status register of the pin selected by routing field bits [2c+1:2c]. The status registers are at address 3 for pin 1, address 4 for pin 2 and address 5 for pin 3. The selected pin goes low two clock edges after the rise when that pin is unmasked and in hold mode. The other pins stay high.
- R3: A routing field of 0 disables its condition. A rise then sets no status bit and moves no pin.
- R4: In hold mode (mode bit k-1 = 0 for pin k), the pin stays low until its status register is read. The read returns the latched bits and clears them. The pin returns high one edge after the read edge.
- R5: In pulse mode (mode bit k-1 = 1), an event drives pin k low two edges after the rise. The pin stays low for exactly PULSE_CYCLES clock cycles and then returns high.
- R6: An event that arrives while a pulse is active neither extends nor restarts that pulse, and produces no later pulse.
- R7: Setting mask bit k-1 at address 0 keeps pin k high while status still latches. Clearing the mask with bits pending in hold mode drives the pin low one edge after the write edge.
- R8: If a status read-clear and a new rising event for the same register fall in the same cycle, the new event's bit is set afterwards.
- R9: A rising edge on error input e sets bit e of the error status register (address 6). The error pin goes low two edges later and stays low while any error bit is set. The masks do not affect the error pin.
- R10: An error bit clears when the error status register is read or when its input falls. A new error rise in the read cycle survives the read. The error pin returns high once the register is zero.
- R11: A condition held high latches only once. After its status bit is read, it stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_in | input | N_COND | Event conditions, latched on rising edge |
| err_in | input | N_ERR | Error conditions |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears status registers) |
| host_addr | input | 3 | Register address |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, valid while host_rd is high |
| irq_n | output | 3 | General-purpose interrupt pins, bit k for pin k+1, active low |
| err_n | output | 1 | Error pin, active low |

## Verification
Two pairs of functions can meet in one cycle:
- a host read-clear of a status register and a new rising event into that same register;
- an error read-clear and a new error rise.

The bench provokes each overlap by raising the new input on the same falling edge at which it starts the read. It judges the result in two ways. The read data must show only the bits that were latched before the overlap. A second read must show the new bit alone, while the pin stays asserted.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int N_OUT = 3;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_LEVEL = 2'd1,
        OUT_PULSE = 2'd2
    } out_state_t;

    localparam logic [2:0] ADDR_MASK  = 3'd0;
    localparam logic [2:0] ADDR_MODE  = 3'd1;
    localparam logic [2:0] ADDR_ROUTE = 3'd2;
    localparam logic [2:0] ADDR_STAT1 = 3'd3;
    localparam logic [2:0] ADDR_STAT2 = 3'd4;
    localparam logic [2:0] ADDR_STAT3 = 3'd5;
    localparam logic [2:0] ADDR_ERR   = 3'd6;

endpackage

// File: rtl/irq_host_regs.sv
module irq_host_regs
    import irq_router_pkg::*;
#(
    parameter int N_COND = 8,
    parameter int N_ERR  = 4,
    parameter int DW     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_wr,
    input  logic                           host_rd,
    input  logic [2:0]                     host_addr,
    input  logic [DW-1:0]                  host_wdata,
    input  logic [N_OUT-1:0][N_COND-1:0]   stat,
    input  logic [N_ERR-1:0]               err_stat,
    output logic [DW-1:0]                  host_rdata,
    output logic [N_OUT-1:0]               mask_q,
    output logic [N_OUT-1:0]               mode_q,
    output logic [2*N_COND-1:0]            route_q,
    output logic [N_OUT-1:0]               stat_clr,
    output logic                           err_clr
);

    localparam int RW = 2 * N_COND;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            mode_q  <= '0;
            route_q <= '0;
        end else if (host_wr) begin
            unique case (host_addr)
                ADDR_MASK:  mask_q  <= host_wdata[N_OUT-1:0];
                ADDR_MODE:  mode_q  <= host_wdata[N_OUT-1:0];
                ADDR_ROUTE: route_q <= host_wdata[RW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int k = 0; k < N_OUT; k++) begin
            stat_clr[k] = host_rd && (host_addr == ADDR_STAT1 + 3'(k));
        end
        err_clr = host_rd && (host_addr == ADDR_ERR);
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            ADDR_MASK:  host_rdata[N_OUT-1:0]  = mask_q;
            ADDR_MODE:  host_rdata[N_OUT-1:0]  = mode_q;
            ADDR_ROUTE: host_rdata[RW-1:0]     = route_q;
            ADDR_STAT1: host_rdata[N_COND-1:0] = stat[0];
            ADDR_STAT2: host_rdata[N_COND-1:0] = stat[1];
            ADDR_STAT3: host_rdata[N_COND-1:0] = stat[2];
            ADDR_ERR:   host_rdata[N_ERR-1:0]  = err_stat;
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
    import irq_router_pkg::*;
#(
    parameter int N_COND = 8,
    parameter int N_ERR  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_COND-1:0]              cond_in,
    input  logic [N_ERR-1:0]               err_in,
    input  logic [2*N_COND-1:0]            route_q,
    input  logic [N_OUT-1:0]               stat_clr,
    input  logic                           err_clr,
    output logic [N_OUT-1:0][N_COND-1:0]   stat,
    output logic [N_OUT-1:0]               evt_q,
    output logic [N_ERR-1:0]               err_stat
);

    logic [N_COND-1:0]              cond_q;
    logic [N_ERR-1:0]               err_q;
    logic [N_COND-1:0]              rise;
    logic [N_ERR-1:0]               err_rise;
    logic [N_OUT-1:0][N_COND-1:0]   hit;

    assign rise     = cond_in & ~cond_q;
    assign err_rise = err_in & ~err_q;

    // route each rising condition to the pin its field selects; field 0 goes nowhere
    generate
        for (genvar k = 0; k < N_OUT; k++) begin : g_out
            for (genvar c = 0; c < N_COND; c++) begin : g_cond
                assign hit[k][c] = rise[c] && (route_q[2*c +: 2] == 2'(k + 1));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q   <= '0;
            err_q    <= '0;
            stat     <= '0;
            evt_q    <= '0;
            err_stat <= '0;
        end else begin
            cond_q <= cond_in;
            err_q  <= err_in;
            for (int k = 0; k < N_OUT; k++) begin
                // a new event beats a simultaneous read-clear
                stat[k]  <= stat_clr[k] ? hit[k] : (stat[k] | hit[k]);
                evt_q[k] <= |hit[k];
            end
            err_stat <= (err_clr ? '0 : (err_stat & err_in)) | err_rise;
        end
    end

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_router_pkg::*;
#(
    parameter int PULSE_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       masked,
    input  logic       pulse_mode,
    input  logic       pending,
    input  logic       evt,
    output out_state_t st_q,
    output logic       pin_n
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    out_state_t    st_d;
    logic [CW-1:0] cnt_q;

    // state register and pulse counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OUT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == OUT_IDLE && st_d == OUT_PULSE) begin
                cnt_q <= LOAD;
            end else if (st_q == OUT_PULSE && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_IDLE: begin
                if (!masked && !pulse_mode && pending) begin
                    st_d = OUT_LEVEL;   // arm-level
                end else if (!masked && pulse_mode && evt) begin
                    st_d = OUT_PULSE;   // fire-pulse
                end
            end
            OUT_LEVEL: begin
                if (masked || pulse_mode || !pending) begin
                    st_d = OUT_IDLE;    // release
                end
            end
            OUT_PULSE: begin
                if (cnt_q == '0) begin
                    st_d = OUT_IDLE;    // expire
                end
            end
            default: st_d = OUT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            OUT_LEVEL, OUT_PULSE: pin_n = 1'b0;
            default:              pin_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_COND       = 8,
    parameter int N_ERR        = 4,
    parameter int DW           = 16,
    parameter int PULSE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] cond_in,
    input  logic [N_ERR-1:0]  err_in,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic [2:0]        irq_n,
    output logic              err_n
);

    logic [N_OUT-1:0][N_COND-1:0] stat;
    logic [N_ERR-1:0]             err_stat;
    logic [N_OUT-1:0]             mask_q;
    logic [N_OUT-1:0]             mode_q;
    logic [2*N_COND-1:0]          route_q;
    logic [N_OUT-1:0]             stat_clr;
    logic                         err_clr;
    logic [N_OUT-1:0]             evt_q;
    out_state_t [N_OUT-1:0]       st_all;

    irq_host_regs #(.N_COND(N_COND), .N_ERR(N_ERR), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .stat(stat), .err_stat(err_stat),
        .host_rdata(host_rdata), .mask_q(mask_q), .mode_q(mode_q),
        .route_q(route_q), .stat_clr(stat_clr), .err_clr(err_clr)
    );

    irq_status_latch #(.N_COND(N_COND), .N_ERR(N_ERR)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .cond_in(cond_in), .err_in(err_in), .route_q(route_q),
        .stat_clr(stat_clr), .err_clr(err_clr),
        .stat(stat), .evt_q(evt_q), .err_stat(err_stat)
    );

    generate
        for (genvar k = 0; k < N_OUT; k++) begin : g_pin
            irq_out_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
                .clk(clk), .rst_n(rst_n),
                .masked(mask_q[k]), .pulse_mode(mode_q[k]),
                .pending(|stat[k]), .evt(evt_q[k]),
                .st_q(st_all[k]), .pin_n(irq_n[k])
            );
        end
    endgenerate

    // error pin is never masked
    always_ff @(posedge clk) begin
        if (!rst_n) err_n <= 1'b1;
        else        err_n <= ~(|err_stat);
    end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int N_COND       = 8,
    parameter int N_ERR        = 4,
    parameter int PULSE_CYCLES = 200
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_COND-1:0]            cond_in,
    input logic [N_ERR-1:0]             err_in,
    input logic [2:0]                   irq_n,
    input logic                         err_n,
    input logic [N_OUT-1:0]             mask_q,
    input logic [N_OUT-1:0]             mode_q,
    input logic [2*N_COND-1:0]          route_q,
    input logic [N_OUT-1:0]             stat_clr,
    input logic [N_OUT-1:0][N_COND-1:0] stat,
    input out_state_t [N_OUT-1:0]       st_all
);

    localparam int CW = $clog2(PULSE_CYCLES + 2);

    // R9: any fresh error rise pulls the error pin low two edges later
    a_r9_err_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_in & ~$past(err_in))) |=> ##1 !err_n);

    generate
        for (genvar k = 0; k < N_OUT; k++) begin : g_k
            logic [CW-1:0] low_run;

            always_ff @(posedge clk) begin
                if (!rst_n) low_run <= '0;
                else if (!irq_n[k] && st_all[k] == OUT_PULSE) low_run <= low_run + 1'b1;
                else low_run <= '0;
            end

            // R5: a pulse never outlasts its window
            a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
                low_run <= CW'(PULSE_CYCLES));

            // R7: a masked pin that is not mid-pulse is high next cycle
            a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
                (mask_q[k] && st_all[k] != OUT_PULSE) |=> irq_n[k]);

            // R4: a held pin stays low until a read clears it
            a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (st_all[k] == OUT_LEVEL && !mask_q[k] && !mode_q[k]
                 && !stat_clr[k] && !$past(stat_clr[k])) |=> !irq_n[k]);

            for (genvar c = 0; c < N_COND; c++) begin : g_c
                // R8: new event wins over simultaneous read-clear
                a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
                    (stat_clr[k] && cond_in[c] && !$past(cond_in[c])
                     && route_q[2*c +: 2] == 2'(k + 1)) |=> stat[k][c]);
            end
        end
    endgenerate

endmodule

bind irq_router irq_router_chk #(
    .N_COND(N_COND), .N_ERR(N_ERR), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .err_in(err_in),
    .irq_n(irq_n), .err_n(err_n), .mask_q(mask_q), .mode_q(mode_q),
    .route_q(route_q), .stat_clr(stat_clr), .stat(stat), .st_all(st_all)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;

    localparam int NC = 8;
    localparam int NE = 4;
    localparam int DW = 16;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] cond_in = '0;
    logic [NE-1:0] err_in = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [2:0]    host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [2:0]    irq_n;
    logic          err_n;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_router #(.N_COND(NC), .N_ERR(NE), .DW(DW), .PULSE_CYCLES(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .err_in(err_in),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_n(irq_n), .err_n(err_n)
    );

    // vector: {cond index[2:0], route sel[1:0], expected irq_n[2:0]}
    localparam logic [7:0] VEC [6] = '{
        {3'd0, 2'd1, 3'b110},
        {3'd3, 2'd2, 3'b101},
        {3'd7, 2'd3, 3'b011},
        {3'd5, 2'd0, 3'b111},
        {3'd2, 2'd2, 3'b101},
        {3'd6, 2'd1, 3'b110}
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        chk("R1 pins", {12'd0, err_n, irq_n}, 16'h000f);
        rd(3'd0, d); chk("R1 mask", d, 16'h0007);
        rd(3'd1, d); chk("R1 mode", d, 16'h0000);
        rd(3'd2, d); chk("R1 route", d, 16'h0000);
        for (int a = 3; a <= 6; a++) begin
            rd(3'(a), d); chk("R1 status", d, 16'h0000);
        end

        wr(3'd0, 16'h0000);

        // R2/R3 table walk
        for (int i = 0; i < 6; i++) begin
            int c;
            int s;
            c = int'(VEC[i][7:5]);
            s = int'(VEC[i][4:3]);
            wr(3'd2, 16'(s) << (2 * c));
            cond_in[c] = 1'b1;
            step(2);
            chk(s == 0 ? "R3 pins" : "R2 pins", {13'd0, irq_n}, {13'd0, VEC[i][2:0]});
            for (int k = 1; k <= 3; k++) begin
                rd(3'(2 + k), d);
                chk(s == 0 ? "R3 status" : "R2 status", d,
                    (k == s) ? (16'h1 << c) : 16'h0);
            end
            cond_in[c] = 1'b0;
            step(1);
            chk("R4 released", {13'd0, irq_n}, 16'h0007);
        end

        // R4: hold until read; R11: held condition latches once
        wr(3'd2, 16'h0001);
        cond_in[0] = 1'b1;
        step(7);
        chk("R4 still low", {15'd0, irq_n[0]}, 16'h0);
        rd(3'd3, d); chk("R4 read", d, 16'h0001);
        step(1);
        chk("R4 high after read", {15'd0, irq_n[0]}, 16'h1);
        step(3);
        chk("R11 no relatch pin", {15'd0, irq_n[0]}, 16'h1);
        rd(3'd3, d); chk("R11 no relatch status", d, 16'h0000);
        cond_in[0] = 1'b0;

        // R5/R6: pulse mode on pin 1, second event mid-pulse
        wr(3'd1, 16'h0001);
        wr(3'd2, 16'h0014);             // cond1 -> pin1, cond2 -> pin1
        cond_in[1] = 1'b1;
        step(2);
        for (int t = 0; t < PW; t++) begin
            if (t == 2) cond_in[2] = 1'b1;
            chk(t == 2 ? "R6 low during pulse" : "R5 low during pulse", {15'd0, irq_n[0]}, 16'h0);
            step(1);
        end
        chk("R5 ends after width", {15'd0, irq_n[0]}, 16'h1);
        step(4);
        chk("R6 no extra pulse", {15'd0, irq_n[0]}, 16'h1);
        rd(3'd3, d); chk("R6 both latched", d, 16'h0006);
        cond_in[2:1] = 2'b00;
        wr(3'd1, 16'h0000);

        // R7: mask pin 2, event latches, unmask asserts
        wr(3'd0, 16'h0002);
        wr(3'd2, 16'h0080);             // cond3 -> pin2
        cond_in[3] = 1'b1;
        step(4);
        chk("R7 masked pin high", {15'd0, irq_n[1]}, 16'h1);
        wr(3'd0, 16'h0000);
        chk("R7 unmask edge", {15'd0, irq_n[1]}, 16'h1);
        step(1);
        chk("R7 low after unmask", {15'd0, irq_n[1]}, 16'h0);
        rd(3'd4, d); chk("R7 latched while masked", d, 16'h0008);
        cond_in[3] = 1'b0;
        step(1);

        // R8: read-clear and new event in same cycle
        wr(3'd2, 16'h0f00);             // cond4,cond5 -> pin3
        cond_in[4] = 1'b1;
        step(2);
        cond_in[5] = 1'b1;
        rd(3'd5, d); chk("R8 first read", d, 16'h0010);
        step(1);
        chk("R8 pin held", {15'd0, irq_n[2]}, 16'h0);
        rd(3'd5, d); chk("R8 new bit survives", d, 16'h0020);
        cond_in[5:4] = 2'b00;
        step(2);

        // R9/R10: error pin, unmaskable, clear by removal and by read
        wr(3'd0, 16'h0007);
        err_in[0] = 1'b1;
        step(2);
        chk("R9 err low", {15'd0, err_n}, 16'h0);
        err_in[0] = 1'b0;
        step(2);
        chk("R10 removal clears", {15'd0, err_n}, 16'h1);
        err_in[1] = 1'b1;
        step(2);
        err_in[3] = 1'b1;
        rd(3'd6, d); chk("R10 read value", d, 16'h0002);
        rd(3'd6, d); chk("R10 new err survives read", d, 16'h0008);
        step(1);
        chk("R10 err high after clear", {15'd0, err_n}, 16'h1);
        rd(3'd6, d); chk("R10 held error stays clear", d, 16'h0000);
        err_in = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule